// File: doc/BRIEF.md
# 8-bit ALU with status flags

A purely combinational 8-bit arithmetic/logic unit for a small register machine. Each evaluation takes a 4-bit operation code, a destination operand, a second operand chosen between a register value and an immediate constant, and the six incoming status flags. It returns the 8-bit result, a strobe saying whether that result is to be written back, and the updated flag vector.

Each operation has its own flag rule. Adds, subtracts and compares update all arithmetic flags. Logic operations keep carry and half-carry. Increment and decrement never touch carry. Compares produce flags but write nothing. Set-register changes no flag at all. The subtract-with-carry and compare-with-carry operations can only clear the zero flag, so that compares over several bytes chain from the least significant byte upward. The unit holds no state. The surrounding pipeline registers its outputs and feeds the flag vector back on the next instruction.

Top module: `alu8_core`

## Requirements
- R1: Opcode 0 (add) and opcode 1 (add with carry, carry-in = flags_in bit 0) give result = d + b (+ C) mod 256, write strobe 1, C = carry out of bit 7, H = carry out of bit 3, V = signed overflow, N = result bit 7, Z = (result == 0).
- R2: Opcode 2 (subtract) and opcode 3 (subtract with carry, borrow-in = C) give result = d - b (- C) mod 256 and write strobe 1. C is set when a borrow leaves bit 7. H is set when a borrow leaves bit 3. V is the signed overflow. N and Z follow the result.
- R3: For opcodes 3 and 5, Z out = (result == 0) AND Z in (flags_in bit 1). A zero result never sets Z unless it was already set.
- R4: Opcode 4 (compare) and opcode 5 (compare with carry) compute the same flags as opcodes 2 and 3 but drive the write strobe to 0.
- R5: Opcodes 6 (AND), 7 (OR) and 8 (XOR) give the bitwise result. They set Z and N from it and force V to 0. C (bit 0) and H (bit 5) pass through unchanged.
- R6: Opcode 9 (one's complement) gives 0xFF - d. It forces C to 1 and V to 0, sets Z and N from the result, and keeps H.
- R7: Opcode 10 (negate) gives 0x00 - d. C = (d != 0), H = borrow out of bit 3, and V = (d == 0x80). Z and N follow the result.
- R8: Opcode 11 (increment) and opcode 12 (decrement) give d + 1 and d - 1 mod 256. V is set exactly for 0x7F to 0x80 (increment) and for 0x80 to 0x7F (decrement). Z and N follow the result. C and H are unchanged.
- R9: Opcode 13 (set register) gives 0xFF with write strobe 1 and flags_out equal to flags_in.
- R10: Every operation that updates N or V outputs S (bit 4) = N (bit 2) XOR V (bit 3).
- R11: Opcodes 14 and 15 are unused. They give write strobe 0, result 0 and flags_out equal to flags_in.
- R12: When use_imm is 1 the second operand b is opnd_k and opnd_r is ignored. When use_imm is 0, b is opnd_r and opnd_k is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation select (encoding in R1 to R11) |
| opnd_d | input | 8 | Destination/first operand |
| opnd_r | input | 8 | Register second operand |
| opnd_k | input | 8 | Immediate second operand |
| use_imm | input | 1 | 1 selects opnd_k as second operand |
| flags_in | input | 6 | Incoming flags: bit0 C, bit1 Z, bit2 N, bit3 V, bit4 S, bit5 H |
| result | output | 8 | Operation result |
| result_we | output | 1 | 1 when the result is to be written back |
| flags_out | output | 6 | Updated flags, same layout as flags_in |

## Verification
The embedded assertions check the following on every evaluation:
- S = N XOR V for every operation that updates N or V.
- The carry of add and subtract agrees with an unsigned magnitude comparison of the operands.
- Compares never raise the write strobe.
- Increment and decrement keep carry.
- The chained zero flag can only be cleared.
- Set-register leaves the flags untouched.

Only the bench's directed scenarios show the rest:
- Exact half-carry and overflow values at the nibble and sign boundaries.
- Negate of 0x00 and 0x80.
- That the unselected second operand and the unused opcodes have no effect.
- Agreement with an integer reference across a pseudo-random sweep of all fourteen operations.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int unsigned OP_W   = 4;
  localparam int unsigned FLAG_W = 6;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'd0,
    OP_ADC   = 4'd1,
    OP_SUB   = 4'd2,
    OP_SBC   = 4'd3,
    OP_CMP   = 4'd4,
    OP_CMPC  = 4'd5,
    OP_AND   = 4'd6,
    OP_OR    = 4'd7,
    OP_XOR   = 4'd8,
    OP_INV   = 4'd9,
    OP_NEG   = 4'd10,
    OP_INC   = 4'd11,
    OP_DEC   = 4'd12,
    OP_ONES  = 4'd13,
    OP_RSV14 = 4'd14,
    OP_RSV15 = 4'd15
  } alu_op_e;

  // bit 0 is carry, bit 5 is half-carry
  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } alu_flags_t;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_INV = 2'd3
  } logic_sel_e;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         h_out,
  output logic         v_out
);

  localparam int unsigned HB = W / 2;

  logic [W:0]  full;
  logic [HB:0] low;
  logic        sa, sb, sr;

  always_comb begin
    if (sub) begin
      full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
      low  = {1'b0, a[HB-1:0]} - {1'b0, b[HB-1:0]} - {{HB{1'b0}}, cin};
    end else begin
      full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      low  = {1'b0, a[HB-1:0]} + {1'b0, b[HB-1:0]} + {{HB{1'b0}}, cin};
    end
  end

  assign res   = full[W-1:0];
  assign c_out = full[W];
  assign h_out = low[HB];

  assign sa = a[W-1];
  assign sb = b[W-1];
  assign sr = res[W-1];

  // overflow: operands of matching sign (add) or opposite sign (sub) and result sign flips
  assign v_out = sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_sel_e   sel,
  output logic [W-1:0] res
);

  always_comb begin
    unique case (sel)
      LG_AND:  res = a & b;
      LG_OR:   res = a | b;
      LG_XOR:  res = a ^ b;
      default: res = ~a;
    endcase
  end

endmodule

// File: rtl/alu8_flagsel.sv
module alu8_flagsel
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e      op,
  input  alu_flags_t   f_in,
  input  logic [W-1:0] ar_res,
  input  logic         ar_c,
  input  logic         ar_h,
  input  logic         ar_v,
  input  logic [W-1:0] lg_res,
  output logic [W-1:0] res,
  output logic         we,
  output alu_flags_t   f_out
);

  logic zero_ar, zero_lg;

  assign zero_ar = (ar_res == '0);
  assign zero_lg = (lg_res == '0);

  always_comb begin
    res   = '0;
    we    = 1'b0;
    f_out = f_in;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CMPC, OP_NEG: begin
        res     = ar_res;
        we      = (op != OP_CMP) && (op != OP_CMPC);
        f_out.c = ar_c;
        f_out.h = ar_h;
        f_out.v = ar_v;
        f_out.n = ar_res[W-1];
        f_out.z = (op == OP_SBC || op == OP_CMPC) ? (zero_ar & f_in.z) : zero_ar;
        f_out.s = ar_res[W-1] ^ ar_v;
      end
      OP_INC, OP_DEC: begin
        res     = ar_res;
        we      = 1'b1;
        f_out.v = ar_v;
        f_out.n = ar_res[W-1];
        f_out.z = zero_ar;
        f_out.s = ar_res[W-1] ^ ar_v;
      end
      OP_AND, OP_OR, OP_XOR, OP_INV: begin
        res     = lg_res;
        we      = 1'b1;
        f_out.v = 1'b0;
        f_out.n = lg_res[W-1];
        f_out.z = zero_lg;
        f_out.s = lg_res[W-1];
        if (op == OP_INV) f_out.c = 1'b1;
      end
      OP_ONES: begin
        res = '1;
        we  = 1'b1;
      end
      default: begin
        res   = '0;
        we    = 1'b0;
        f_out = f_in;
      end
    endcase
  end

  // chained zero may only be cleared by the carry-subtract family
  always_comb begin
    if ((op == OP_SBC || op == OP_CMPC) && !f_in.z) begin
      assert_chain_zero_R3: assert (!f_out.z);
    end
    if (op == OP_INV) begin
      assert_inv_carry_R6: assert (f_out.c && !f_out.v && (f_out.h == f_in.h));
    end
    if (op == OP_AND || op == OP_OR || op == OP_XOR) begin
      assert_logic_keep_R5: assert ((f_out.c == f_in.c) && (f_out.h == f_in.h) && !f_out.v);
    end
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [3:0]   op_code,
  input  logic [W-1:0] opnd_d,
  input  logic [W-1:0] opnd_r,
  input  logic [W-1:0] opnd_k,
  input  logic         use_imm,
  input  logic [5:0]   flags_in,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic [5:0]   flags_out
);

  alu_op_e    op;
  alu_flags_t f_in, f_out;
  logic [W-1:0] src_b;

  logic [W-1:0] ar_a, ar_b, ar_res, lg_res;
  logic         ar_cin, ar_sub, ar_c, ar_h, ar_v;
  logic_sel_e   lg_sel;

  assign op    = alu_op_e'(op_code);
  assign f_in  = alu_flags_t'(flags_in);
  assign src_b = use_imm ? opnd_k : opnd_r;

  // arithmetic operand steering
  always_comb begin
    ar_a   = opnd_d;
    ar_b   = src_b;
    ar_cin = 1'b0;
    ar_sub = 1'b0;
    unique case (op)
      OP_ADC:          ar_cin = f_in.c;
      OP_SUB, OP_CMP:  ar_sub = 1'b1;
      OP_SBC, OP_CMPC: begin ar_sub = 1'b1; ar_cin = f_in.c; end
      OP_NEG:          begin ar_a = '0; ar_b = opnd_d; ar_sub = 1'b1; end
      OP_INC:          ar_b = W'(1);
      OP_DEC:          begin ar_b = W'(1); ar_sub = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    unique case (op)
      OP_AND:  lg_sel = LG_AND;
      OP_OR:   lg_sel = LG_OR;
      OP_XOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_INV;
    endcase
  end

  alu8_arith #(.W(W)) u_arith (
    .a(ar_a), .b(ar_b), .cin(ar_cin), .sub(ar_sub),
    .res(ar_res), .c_out(ar_c), .h_out(ar_h), .v_out(ar_v)
  );

  alu8_logic #(.W(W)) u_logic (
    .a(opnd_d), .b(src_b), .sel(lg_sel), .res(lg_res)
  );

  alu8_flagsel #(.W(W)) u_flags (
    .op(op), .f_in(f_in),
    .ar_res(ar_res), .ar_c(ar_c), .ar_h(ar_h), .ar_v(ar_v),
    .lg_res(lg_res),
    .res(result), .we(result_we), .f_out(f_out)
  );

  assign flags_out = f_out;

  logic updates_nv;
  assign updates_nv = (op_code <= 4'd12);

  always_comb begin
    if (updates_nv) begin
      assert_sign_rule_R10: assert (flags_out[4] == (flags_out[2] ^ flags_out[3]));
    end
    if (op == OP_ADD) begin
      assert_add_carry_R1: assert (flags_out[0] == (result < opnd_d));
    end
    if (op == OP_SUB) begin
      assert_sub_borrow_R2: assert (flags_out[0] == (src_b > opnd_d));
    end
    if (op == OP_CMP || op == OP_CMPC) begin
      assert_cmp_nowrite_R4: assert (!result_we);
    end
    if (op == OP_INC || op == OP_DEC) begin
      assert_incdec_carry_R8: assert (flags_out[0] == flags_in[0] && flags_out[5] == flags_in[5]);
    end
    if (op == OP_ONES) begin
      assert_ones_flags_R9: assert (flags_out == flags_in && result == '1);
    end
    if (op_code > 4'd13) begin
      assert_unused_op_R11: assert (!result_we && flags_out == flags_in);
    end
  end

endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [3:0] op_code;
  logic [7:0] opnd_d, opnd_r, opnd_k;
  logic       use_imm;
  logic [5:0] flags_in;
  logic [7:0] result;
  logic       result_we;
  logic [5:0] flags_out;

  alu8_core dut (
    .op_code(op_code), .opnd_d(opnd_d), .opnd_r(opnd_r), .opnd_k(opnd_k),
    .use_imm(use_imm), .flags_in(flags_in),
    .result(result), .result_we(result_we), .flags_out(flags_out)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int sx(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // integer reference built from the requirement text
  task automatic model(input int op, input int d, input int b, input logic [5:0] fi,
                       output logic we, output logic [7:0] r, output logic [5:0] fo);
    int aa, bb, ci, u, sv, rr;
    logic c, z, n, v, h;
    c = fi[0]; z = fi[1]; n = fi[2]; v = fi[3]; h = fi[5];
    fo = fi; we = 1'b1; rr = 0;
    if (op <= 1 || op == 11) begin
      bb = (op == 11) ? 1 : b;
      ci = (op == 1) ? int'(c) : 0;
      u = d + bb + ci; rr = u % 256;
      sv = sx(d) + sx(bb) + ci;
      if (op != 11) begin c = (u > 255); h = ((d % 16) + (bb % 16) + ci) > 15; end
      v = (sv > 127) || (sv < -128);
    end else if ((op >= 2 && op <= 5) || op == 10 || op == 12) begin
      aa = (op == 10) ? 0 : d;
      bb = (op == 12) ? 1 : ((op == 10) ? d : b);
      ci = (op == 3 || op == 5) ? int'(c) : 0;
      u = aa - bb - ci; rr = (u + 512) % 256;
      sv = sx(aa) - sx(bb) - ci;
      if (op != 12) begin c = (u < 0); h = ((aa % 16) - (bb % 16) - ci) < 0; end
      v = (sv > 127) || (sv < -128);
      if (op == 4 || op == 5) we = 1'b0;
    end else if (op >= 6 && op <= 9) begin
      case (op)
        6: rr = d & b;
        7: rr = d | b;
        8: rr = d ^ b;
        default: begin rr = 255 - d; c = 1'b1; end
      endcase
      v = 1'b0;
    end else if (op == 13) begin
      r = 8'hFF; return;
    end else begin
      we = 1'b0; r = 8'h00; return;
    end
    n = (rr >= 128);
    z = (rr == 0) && ((op == 3 || op == 5) ? fi[1] : 1'b1);
    r = rr[7:0];
    fo = {h, n ^ v, v, n, z, c};
  endtask

  task automatic drive(input int op, input int d, input int rv, input int k,
                       input logic imm, input logic [5:0] fi);
    @(negedge clk);
    op_code = op[3:0]; opnd_d = d[7:0]; opnd_r = rv[7:0]; opnd_k = k[7:0];
    use_imm = imm; flags_in = fi;
    #2;
  endtask

  task automatic check(input string req, input logic [7:0] er, input logic ewe,
                       input logic [5:0] ef);
    checks++;
    if (result !== er || result_we !== ewe || flags_out !== ef) begin
      fails++;
      $display("FAIL %s op=%0d d=%h: got r=%h we=%b f=%b exp r=%h we=%b f=%b",
               req, op_code, opnd_d, result, result_we, flags_out, er, ewe, ef);
    end
  endtask

  task automatic run(input string req, input int op, input int d, input int b, input logic [5:0] fi);
    logic we; logic [7:0] r; logic [5:0] fo;
    drive(op, d, b, 8'h5A, 1'b0, fi);
    model(op, d, b, fi, we, r, fo);
    check(req, r, we, fo);
  endtask

  task automatic t_unused_R11;
    drive(14, 8'h33, 8'h44, 0, 1'b0, 6'b101010); check("R11", 8'h00, 1'b0, 6'b101010);
    drive(15, 8'hFF, 8'h01, 0, 1'b1, 6'b010101); check("R11", 8'h00, 1'b0, 6'b010101);
  endtask

  task automatic t_add_R1;
    drive(0, 8'h0F, 8'h01, 0, 1'b0, 6'b0);  check("R1", 8'h10, 1'b1, 6'b100000); // H only
    drive(0, 8'h7F, 8'h01, 0, 1'b0, 6'b0);  check("R1", 8'h80, 1'b1, 6'b101100); // H V N, S=0
    drive(0, 8'hFF, 8'h01, 0, 1'b0, 6'b0);  check("R1", 8'h00, 1'b1, 6'b100011); // H Z C
    drive(1, 8'h80, 8'h7F, 0, 1'b0, 6'b000001); check("R1", 8'h00, 1'b1, 6'b100011);
  endtask

  task automatic t_sub_R2;
    drive(2, 8'h10, 8'h01, 0, 1'b0, 6'b0);  check("R2", 8'h0F, 1'b1, 6'b100000);
    drive(2, 8'h00, 8'h01, 0, 1'b0, 6'b0);  check("R2", 8'hFF, 1'b1, 6'b110101);
    drive(2, 8'h80, 8'h01, 0, 1'b0, 6'b0);  check("R2", 8'h7F, 1'b1, 6'b111000);
    drive(3, 8'h05, 8'h04, 0, 1'b0, 6'b000011); check("R2", 8'h00, 1'b1, 6'b000010);
  endtask

  task automatic t_chain_R3;
    drive(3, 8'h05, 8'h05, 0, 1'b0, 6'b000000); check("R3", 8'h00, 1'b1, 6'b000000);
    drive(3, 8'h05, 8'h05, 0, 1'b0, 6'b000010); check("R3", 8'h00, 1'b1, 6'b000010);
    drive(5, 8'h05, 8'h04, 0, 1'b0, 6'b000001); check("R3", 8'h00, 1'b0, 6'b000000);
  endtask

  task automatic t_cmp_R4;
    drive(4, 8'h20, 8'h20, 0, 1'b0, 6'b0);  check("R4", 8'h00, 1'b0, 6'b000010);
    drive(4, 8'h01, 8'h02, 0, 1'b0, 6'b0);  check("R4", 8'hFF, 1'b0, 6'b110101);
  endtask

  task automatic t_logic_R5;
    drive(6, 8'hF0, 8'h0F, 0, 1'b0, 6'b101001); check("R5", 8'h00, 1'b1, 6'b100011);
    drive(7, 8'h80, 8'h01, 0, 1'b0, 6'b001000); check("R5", 8'h81, 1'b1, 6'b010100);
    drive(8, 8'hAA, 8'hAA, 0, 1'b0, 6'b000001); check("R5", 8'h00, 1'b1, 6'b000011);
  endtask

  task automatic t_inv_R6;
    drive(9, 8'h00, 0, 0, 1'b0, 6'b101000); check("R6", 8'hFF, 1'b1, 6'b110101);
    drive(9, 8'hFF, 0, 0, 1'b0, 6'b000000); check("R6", 8'h00, 1'b1, 6'b000011);
  endtask

  task automatic t_neg_R7;
    drive(10, 8'h00, 0, 0, 1'b0, 6'b000001); check("R7", 8'h00, 1'b1, 6'b000010);
    drive(10, 8'h80, 0, 0, 1'b0, 6'b0);      check("R7", 8'h80, 1'b1, 6'b001101);
    drive(10, 8'h01, 0, 0, 1'b0, 6'b0);      check("R7", 8'hFF, 1'b1, 6'b110101);
  endtask

  task automatic t_incdec_R8;
    drive(11, 8'h7F, 0, 0, 1'b0, 6'b100001); check("R8", 8'h80, 1'b1, 6'b101101);
    drive(11, 8'hFF, 0, 0, 1'b0, 6'b000000); check("R8", 8'h00, 1'b1, 6'b000010);
    drive(12, 8'h80, 0, 0, 1'b0, 6'b000001); check("R8", 8'h7F, 1'b1, 6'b011001);
    drive(12, 8'h00, 0, 0, 1'b0, 6'b000000); check("R8", 8'hFF, 1'b1, 6'b010100);
  endtask

  task automatic t_ones_R9;
    drive(13, 8'h12, 8'h34, 0, 1'b0, 6'b011010); check("R9", 8'hFF, 1'b1, 6'b011010);
  endtask

  task automatic t_immsel_R12;
    drive(0, 8'h10, 8'hFF, 8'h01, 1'b1, 6'b0); check("R12", 8'h11, 1'b1, 6'b000000);
    drive(0, 8'h10, 8'h01, 8'hFF, 1'b0, 6'b0); check("R12", 8'h11, 1'b1, 6'b000000);
    drive(6, 8'hF0, 8'h00, 8'h3C, 1'b1, 6'b0); check("R12", 8'h30, 1'b1, 6'b000000);
  endtask

  task automatic t_sweep_R10;
    for (int op = 0; op < 16; op++) begin
      for (int i = 0; i < 24; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        run("R10", op, int'(lfsr[7:0]), int'(lfsr[15:8]), lfsr[5:0] ^ lfsr[13:8]);
        checks++;
        if (op <= 12 && flags_out[4] !== (flags_out[2] ^ flags_out[3])) begin
          fails++;
          $display("FAIL R10 op=%0d got S=%b exp S=%b", op, flags_out[4], flags_out[2] ^ flags_out[3]);
        end
      end
    end
  endtask

  initial begin
    op_code = 4'd14; opnd_d = '0; opnd_r = '0; opnd_k = '0; use_imm = 1'b0; flags_in = '0;
    repeat (2) @(posedge clk);
    t_unused_R11();
    t_add_R1();
    t_sub_R2();
    t_chain_R3();
    t_cmp_R4();
    t_logic_R5();
    t_inv_R6();
    t_neg_R7();
    t_incdec_R8();
    t_ones_R9();
    t_immsel_R12();
    t_sweep_R10();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule